// File: doc/BRIEF.md
# Debug Interrupt Entry and Return Arbiter

This block decides when a processor core takes a debug interrupt and which save/restore register pair records the interrupted context. Comparator hits, branch and trap indications, and critical-interrupt notifications come in as single-cycle flags. Each flag is gated by its own enable and latched into a sticky status register. An entry is granted once a latched event is present, internal debug mode is on, the live machine-state debug-enable bit is set, and no exception of higher rank is pending.

On entry the block issues one-cycle strobes. These write the PC and machine state into the dedicated debug pair when the debug extension is enabled, or into the critical pair when it is not. The block also presents a new machine-state value for the core to write. In that value the debug-enable bit is cleared, and the external and critical enables are cleared only where their clear-on-entry configuration bits ask for it.

A return-from-debug request received while the handler runs produces a one-cycle PC-restore strobe. In the same cycle it writes back the machine state saved in the debug pair. The controller cycles through four named states:
- `ST_RUN`: normal execution.
- `ST_TAKE`: the entry cycle.
- `ST_HANDLER`: the debug handler is running.
- `ST_RESTORE`: the return cycle.

Its transitions are:
- run-to-take, when the entry condition holds;
- take-to-handler, always;
- handler-to-restore, on a return request;
- restore-to-run, always.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: In `ST_RUN` the block enters `ST_TAKE` only when the status register is non-zero, `int_dbg_mode` is 1, `cur_msr[2]` (debug enable) is 1 and `hp_pend` is 0. `dbg_take` is high for exactly the `ST_TAKE` cycle, one clock after the deciding cycle.
- R2: With `dbg_ext_en`=1 at the deciding cycle, `pair_dbg`=1 and the entry pulses `dsrr_we` and not `csrr_we`.
- R3: With `dbg_ext_en`=0 at the deciding cycle, `pair_dbg`=0 and the entry pulses `csrr_we` and not `dsrr_we`.
- R4: `rfdi` in `ST_HANDLER` leads to one `ST_RESTORE` cycle with `pc_restore`=1, `msr_we`=1 and `msr_new`=`saved_msr`. `rfdi` in any other state has no effect.
- R5: During entry, `msr_new[1]` (external enable) = `cur_msr[1]` & ~`clr_ee_cfg` and `msr_new[0]` (critical enable) = `cur_msr[0]` & ~`clr_ce_cfg`.
- R6: `itlb_miss` or `isi_fault` blocks entry unless status bit 0 (instruction address compare) is set. In that case entry proceeds.
- R7: Status bit 1 (data address compare) sets only when `ev_dac`, `ev_en[1]` and `ev_iac` are all 1 in the same cycle.
- R8: A trap with `ev_en[3]`=1 and `cur_msr[2]`=1 sets status bit 3 and keeps `trap_prog_req` low. Any other trap raises `trap_prog_req` in the same cycle and leaves bit 3 alone.
- R9: Status bits 0, 2, 4 and 5 (instruction compare, branch taken, critical taken, critical return) set from their flags only when the matching `ev_en` bit is 1.
- R10: Status bits set one clock after their gated event and stay set until `sts_w1c` writes 1 to them. A set and a clear of the same bit in the same cycle leave it set.
- R11: During entry `msr_we`=1 and `msr_new[2]`=0.
- R12: After reset the state is `ST_RUN`, the status is 0 and every strobe is low. `msr_we` is high only in `ST_TAKE` and `ST_RESTORE`, and `msr_new` is 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_iac | input | 1 | Instruction address compare hit |
| ev_dac | input | 1 | Data address compare hit |
| ev_brt | input | 1 | Branch taken |
| ev_trap | input | 1 | Trap condition |
| ev_cit | input | 1 | Critical interrupt taken |
| ev_crt | input | 1 | Return-from-critical executed |
| ev_en | input | 6 | Per-event enables, bit order as status |
| itlb_miss | input | 1 | Instruction TLB miss on current instruction |
| isi_fault | input | 1 | Instruction storage fault on current instruction |
| hp_pend | input | 1 | Other higher-priority exception pending |
| dbg_ext_en | input | 1 | Debug extension enable (dedicated pair) |
| int_dbg_mode | input | 1 | Internal debug mode |
| cur_msr | input | 3 | Live machine state {DE, EE, CE} |
| clr_ee_cfg | input | 1 | Clear external enable on entry |
| clr_ce_cfg | input | 1 | Clear critical enable on entry |
| sts_w1c | input | 6 | Write-one-to-clear for status |
| rfdi | input | 1 | Return-from-debug request |
| saved_msr | input | 3 | Machine state held in the debug pair |
| dbg_take | output | 1 | Debug interrupt entry strobe |
| pair_dbg | output | 1 | 1: debug pair selected, 0: critical pair |
| dsrr_we | output | 1 | Debug pair capture strobe |
| csrr_we | output | 1 | Critical pair capture strobe |
| pc_restore | output | 1 | Return redirect strobe |
| msr_we | output | 1 | Machine-state write strobe |
| msr_new | output | 3 | Machine-state value to write |
| dbg_status | output | 6 | Sticky event status |
| trap_prog_req | output | 1 | Program interrupt request for a trap |

## Verification
Single events of each kind are applied with their enable on and off, so that gating is told apart from latching. Data compare hits are applied with and without a coincident instruction compare hit, which separates the linked rule from plain gating. Traps are applied with debug enable set and clear, which shows which of the two interrupt paths receives them. Entries are provoked with each value of the extension bit and of the clear-on-entry bits, with internal debug mode off, and with a TLB miss present while only a branch event is latched and then with an instruction compare latched; this separates the blocking ranks. Return requests are given both inside the handler and in normal running, and clears are given that coincide with new events.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
    localparam int NEV     = 6;
    localparam int EV_IAC  = 0;
    localparam int EV_DAC  = 1;
    localparam int EV_BRT  = 2;
    localparam int EV_TRAP = 3;
    localparam int EV_CIT  = 4;
    localparam int EV_CRT  = 5;
    localparam int MSR_W   = 3;
    localparam int MSR_DE  = 2;
    localparam int MSR_EE  = 1;
    localparam int MSR_CE  = 0;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_TAKE    = 2'd1,
        ST_HANDLER = 2'd2,
        ST_RESTORE = 2'd3
    } dbg_state_e;
endpackage

// File: rtl/dbg_evt_gate.sv
module dbg_evt_gate
    import dbg_arb_pkg::*;
(
    input  logic [NEV-1:0] raw_ev,
    input  logic [NEV-1:0] ev_en,
    input  logic           msr_de,
    output logic [NEV-1:0] set_vec,
    output logic           trap_prog_req
);
    logic trap_to_dbg;

    always_comb begin
        trap_to_dbg = raw_ev[EV_TRAP] & ev_en[EV_TRAP] & msr_de;
        set_vec = raw_ev & ev_en;
        // data compare counts only when linked to an instruction compare hit
        set_vec[EV_DAC]  = raw_ev[EV_DAC] & ev_en[EV_DAC] & raw_ev[EV_IAC];
        set_vec[EV_TRAP] = trap_to_dbg;
        trap_prog_req = raw_ev[EV_TRAP] & ~trap_to_dbg;
    end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sts
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sts[i] <= 1'b0;
            else if (set_vec[i])
                sts[i] <= 1'b1;
            else if (clr_vec[i])
                sts[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEV-1:0]   sts,
    input  logic             idm,
    input  logic [MSR_W-1:0] cur_msr,
    input  logic             itlb_miss,
    input  logic             isi_fault,
    input  logic             hp_pend,
    input  logic             ext_en,
    input  logic             clr_ee,
    input  logic             clr_ce,
    input  logic             rfdi,
    input  logic [MSR_W-1:0] saved_msr,
    output logic             take,
    output logic             pair_dbg,
    output logic             dsrr_we,
    output logic             csrr_we,
    output logic             pc_restore,
    output logic             msr_we,
    output logic [MSR_W-1:0] msr_new
);
    dbg_state_e state_q, state_d;
    logic       sel_q;
    logic       fetch_block;
    logic       go;

    always_comb begin
        fetch_block = (itlb_miss | isi_fault) & ~sts[EV_IAC];
        go = (|sts) & idm & cur_msr[MSR_DE] & ~hp_pend & ~fetch_block;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (go) state_d = ST_TAKE;
            ST_TAKE:    state_d = ST_HANDLER;
            ST_HANDLER: if (rfdi) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && go)
                sel_q <= ext_en;
        end
    end

    always_comb begin
        take       = 1'b0;
        dsrr_we    = 1'b0;
        csrr_we    = 1'b0;
        pc_restore = 1'b0;
        msr_we     = 1'b0;
        msr_new    = '0;
        unique case (state_q)
            ST_RUN, ST_HANDLER: ;
            ST_TAKE: begin
                take    = 1'b1;
                dsrr_we = sel_q;
                csrr_we = ~sel_q;
                msr_we  = 1'b1;
                msr_new[MSR_DE] = 1'b0;
                msr_new[MSR_EE] = cur_msr[MSR_EE] & ~clr_ee;
                msr_new[MSR_CE] = cur_msr[MSR_CE] & ~clr_ce;
            end
            ST_RESTORE: begin
                pc_restore = 1'b1;
                msr_we     = 1'b1;
                msr_new    = saved_msr;
            end
        endcase
        pair_dbg = sel_q;
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_iac,
    input  logic             ev_dac,
    input  logic             ev_brt,
    input  logic             ev_trap,
    input  logic             ev_cit,
    input  logic             ev_crt,
    input  logic [NEV-1:0]   ev_en,
    input  logic             itlb_miss,
    input  logic             isi_fault,
    input  logic             hp_pend,
    input  logic             dbg_ext_en,
    input  logic             int_dbg_mode,
    input  logic [MSR_W-1:0] cur_msr,
    input  logic             clr_ee_cfg,
    input  logic             clr_ce_cfg,
    input  logic [NEV-1:0]   sts_w1c,
    input  logic             rfdi,
    input  logic [MSR_W-1:0] saved_msr,
    output logic             dbg_take,
    output logic             pair_dbg,
    output logic             dsrr_we,
    output logic             csrr_we,
    output logic             pc_restore,
    output logic             msr_we,
    output logic [MSR_W-1:0] msr_new,
    output logic [NEV-1:0]   dbg_status,
    output logic             trap_prog_req
);
    logic [NEV-1:0] raw_ev;
    logic [NEV-1:0] set_vec;

    always_comb begin
        raw_ev          = '0;
        raw_ev[EV_IAC]  = ev_iac;
        raw_ev[EV_DAC]  = ev_dac;
        raw_ev[EV_BRT]  = ev_brt;
        raw_ev[EV_TRAP] = ev_trap;
        raw_ev[EV_CIT]  = ev_cit;
        raw_ev[EV_CRT]  = ev_crt;
    end

    dbg_evt_gate u_gate (
        .raw_ev        (raw_ev),
        .ev_en         (ev_en),
        .msr_de        (cur_msr[MSR_DE]),
        .set_vec       (set_vec),
        .trap_prog_req (trap_prog_req)
    );

    dbg_status_reg #(.W(NEV)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (sts_w1c),
        .sts     (dbg_status)
    );

    dbg_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts        (dbg_status),
        .idm        (int_dbg_mode),
        .cur_msr    (cur_msr),
        .itlb_miss  (itlb_miss),
        .isi_fault  (isi_fault),
        .hp_pend    (hp_pend),
        .ext_en     (dbg_ext_en),
        .clr_ee     (clr_ee_cfg),
        .clr_ce     (clr_ce_cfg),
        .rfdi       (rfdi),
        .saved_msr  (saved_msr),
        .take       (dbg_take),
        .pair_dbg   (pair_dbg),
        .dsrr_we    (dsrr_we),
        .csrr_we    (csrr_we),
        .pc_restore (pc_restore),
        .msr_we     (msr_we),
        .msr_new    (msr_new)
    );
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_trap,
    input logic [5:0] ev_en,
    input logic       int_dbg_mode,
    input logic       hp_pend,
    input logic [2:0] cur_msr,
    input logic [5:0] sts_w1c,
    input logic [2:0] saved_msr,
    input logic       dbg_take,
    input logic       pair_dbg,
    input logic       dsrr_we,
    input logic       csrr_we,
    input logic       pc_restore,
    input logic       msr_we,
    input logic [2:0] msr_new,
    input logic [5:0] dbg_status,
    input logic       trap_prog_req
);
    // R1
    take_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> ($past(|dbg_status) && $past(int_dbg_mode)
                      && $past(cur_msr[2]) && !$past(hp_pend)));

    // R12
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> !dbg_take);

    // R2
    dbg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_take && pair_dbg) |-> (dsrr_we && !csrr_we));

    // R3
    crit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_take && !pair_dbg) |-> (csrr_we && !dsrr_we));

    // R11
    de_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> (msr_we && !msr_new[2]));

    // R4
    restore_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_restore |-> (msr_we && msr_new == saved_msr && !dbg_take));

    // R8
    trap_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_prog_req |-> (ev_trap && !(ev_en[3] && cur_msr[2])));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(dbg_status) & ~$past(sts_w1c) & ~dbg_status) == 6'd0));
endmodule

bind dbg_entry_ctrl dbg_entry_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_trap       (ev_trap),
    .ev_en         (ev_en),
    .int_dbg_mode  (int_dbg_mode),
    .hp_pend       (hp_pend),
    .cur_msr       (cur_msr),
    .sts_w1c       (sts_w1c),
    .saved_msr     (saved_msr),
    .dbg_take      (dbg_take),
    .pair_dbg      (pair_dbg),
    .dsrr_we       (dsrr_we),
    .csrr_we       (csrr_we),
    .pc_restore    (pc_restore),
    .msr_we        (msr_we),
    .msr_new       (msr_new),
    .dbg_status    (dbg_status),
    .trap_prog_req (trap_prog_req)
);

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_iac = 0, ev_dac = 0, ev_brt = 0, ev_trap = 0, ev_cit = 0, ev_crt = 0;
    logic [5:0] ev_en = 6'h3f;
    logic itlb_miss = 0, isi_fault = 0, hp_pend = 0;
    logic dbg_ext_en = 1, int_dbg_mode = 1;
    logic [2:0] cur_msr = 3'b111;
    logic clr_ee_cfg = 0, clr_ce_cfg = 0;
    logic [5:0] sts_w1c = 0;
    logic rfdi = 0;
    logic [2:0] saved_msr = 3'b000;
    logic dbg_take, pair_dbg, dsrr_we, csrr_we, pc_restore, msr_we, trap_prog_req;
    logic [2:0] msr_new;
    logic [5:0] dbg_status;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state: 0 run, 1 take, 2 handler, 3 restore
    int m_state = 0;
    logic [5:0] m_sts = 0;
    logic m_sel = 0;

    always #5 clk = ~clk;

    dbg_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ev_iac(ev_iac), .ev_dac(ev_dac), .ev_brt(ev_brt), .ev_trap(ev_trap),
        .ev_cit(ev_cit), .ev_crt(ev_crt), .ev_en(ev_en),
        .itlb_miss(itlb_miss), .isi_fault(isi_fault), .hp_pend(hp_pend),
        .dbg_ext_en(dbg_ext_en), .int_dbg_mode(int_dbg_mode), .cur_msr(cur_msr),
        .clr_ee_cfg(clr_ee_cfg), .clr_ce_cfg(clr_ce_cfg), .sts_w1c(sts_w1c),
        .rfdi(rfdi), .saved_msr(saved_msr),
        .dbg_take(dbg_take), .pair_dbg(pair_dbg), .dsrr_we(dsrr_we), .csrr_we(csrr_we),
        .pc_restore(pc_restore), .msr_we(msr_we), .msr_new(msr_new),
        .dbg_status(dbg_status), .trap_prog_req(trap_prog_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] gated_set();
        logic [5:0] s;
        s[0] = ev_iac & ev_en[0];
        s[1] = ev_dac & ev_en[1] & ev_iac;
        s[2] = ev_brt & ev_en[2];
        s[3] = ev_trap & ev_en[3] & cur_msr[2];
        s[4] = ev_cit & ev_en[4];
        s[5] = ev_crt & ev_en[5];
        return s;
    endfunction

    // one clock: compare outputs against the model, advance model, apply core MSR write
    task automatic step();
        logic e_take, e_rest, e_we;
        logic [2:0] e_new;
        logic fire;
        #1;
        e_take = (m_state == 1);
        e_rest = (m_state == 3);
        e_we   = e_take | e_rest;
        e_new  = e_take ? {1'b0, cur_msr[1] & ~clr_ee_cfg, cur_msr[0] & ~clr_ce_cfg}
               : e_rest ? saved_msr : 3'b000;
        chk("R1/R6 dbg_take", {7'd0, dbg_take}, {7'd0, e_take});
        chk("R2/R3 pair_dbg", {7'd0, pair_dbg}, {7'd0, m_sel});
        chk("R2 dsrr_we", {7'd0, dsrr_we}, {7'd0, e_take & m_sel});
        chk("R3 csrr_we", {7'd0, csrr_we}, {7'd0, e_take & ~m_sel});
        chk("R4 pc_restore", {7'd0, pc_restore}, {7'd0, e_rest});
        chk("R12 msr_we", {7'd0, msr_we}, {7'd0, e_we});
        chk("R5/R11/R4 msr_new", {5'd0, msr_new}, {5'd0, e_new});
        chk("R7/R9/R10 dbg_status", {2'd0, dbg_status}, {2'd0, m_sts});
        chk("R8 trap_prog_req", {7'd0, trap_prog_req},
            {7'd0, ev_trap & ~(ev_en[3] & cur_msr[2])});
        fire = (m_sts != 0) && int_dbg_mode && cur_msr[2] && !hp_pend
               && !((itlb_miss || isi_fault) && !m_sts[0]);
        @(posedge clk);
        case (m_state)
            0: if (fire) begin m_state = 1; m_sel = dbg_ext_en; end
            1: m_state = 2;
            2: if (rfdi) m_state = 3;
            default: m_state = 0;
        endcase
        m_sts = (m_sts & ~sts_w1c) | gated_set();
        @(negedge clk);
        if (e_take) saved_msr = cur_msr;   // pair captures old state
        if (e_we) cur_msr = e_new;
    endtask

    task automatic quiet();
        ev_iac = 0; ev_dac = 0; ev_brt = 0; ev_trap = 0; ev_cit = 0; ev_crt = 0;
        sts_w1c = 0; rfdi = 0; itlb_miss = 0; isi_fault = 0; hp_pend = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // clear all status from the handler, then return
    task automatic finish_handler();
        sts_w1c = 6'h3f; step(); sts_w1c = 0;
        rfdi = 1; step(); rfdi = 0;
        idle(2);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset take", {7'd0, dbg_take}, 8'd0);
        chk("R12 reset status", {2'd0, dbg_status}, 8'd0);
        chk("R12 reset msr_we", {7'd0, msr_we}, 8'd0);
        rst_n = 1;
        idle(2);

        // R2 R5 R11: instruction compare, extension on, clear EE only
        dbg_ext_en = 1; clr_ee_cfg = 1; clr_ce_cfg = 0;
        ev_iac = 1; step(); quiet();
        idle(3);
        // R4: return request restores the saved state
        finish_handler();

        // R3: extension off, branch taken, clear CE only
        dbg_ext_en = 0; clr_ee_cfg = 0; clr_ce_cfg = 1; cur_msr = 3'b111;
        ev_brt = 1; step(); quiet();
        idle(3);
        finish_handler();
        cur_msr = 3'b111;

        // R4: return request outside the handler is ignored
        rfdi = 1; step(); step(); rfdi = 0; idle(1);

        // R7: data compare alone, then linked with instruction compare
        int_dbg_mode = 0;
        ev_dac = 1; step(); quiet(); idle(1);
        ev_dac = 1; ev_iac = 1; step(); quiet(); idle(1);
        sts_w1c = 6'h3f; step(); quiet();

        // R8: trap with debug enable set, then clear, then trap events off
        ev_trap = 1; step(); quiet(); idle(1);
        cur_msr = 3'b011; ev_trap = 1; step(); quiet();
        cur_msr = 3'b111; ev_en[3] = 0; ev_trap = 1; step(); quiet();
        ev_en = 6'h3f;
        sts_w1c = 6'h3f; step(); quiet();

        // R9: critical taken / return with enables off, then on
        ev_en[4] = 0; ev_en[5] = 0; ev_cit = 1; ev_crt = 1; step(); quiet(); idle(1);
        ev_en = 6'h3f; ev_cit = 1; step(); quiet(); ev_crt = 1; step(); quiet(); idle(1);

        // R10: clear and set of the same bit in one cycle keeps it set
        ev_cit = 1; sts_w1c = 6'h10; step(); quiet(); idle(1);
        sts_w1c = 6'h30; step(); quiet(); idle(1);

        // R1: status pending but internal debug mode off: no entry; then on
        ev_brt = 1; step(); quiet(); idle(2);
        // R6: fetch fault blocks when only branch latched
        int_dbg_mode = 1; itlb_miss = 1; step(); step(); quiet();
        // R1: higher-priority exception blocks even with instruction compare
        ev_iac = 1; hp_pend = 1; itlb_miss = 1; step(); ev_iac = 0; step(); step();
        // R6: instruction compare latched overrides the fetch fault
        hp_pend = 0; isi_fault = 1; dbg_ext_en = 1; clr_ee_cfg = 1; clr_ce_cfg = 1;
        step(); quiet(); idle(3);
        finish_handler();

        // R1: debug enable clear in live state blocks entry
        cur_msr = 3'b011; ev_brt = 1; step(); quiet(); idle(2);
        cur_msr = 3'b111; idle(3);
        finish_handler();
        idle(2);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule